// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits behind the bus front end of a byte-wide flash device. It reads each bus write as a command byte, or as the operand of a command that needs two writes. It keeps track of what later bus reads return: the array contents, the status byte or the identification codes. It starts, pauses and resumes a modelled program/erase engine. That engine counts a parameterised number of cycles and then applies its change to a small behavioural storage array in a single step.

Block protection arrives as one lock flag per block. A program or erase aimed at a locked block is refused, and the status byte records why. The error flags in the status byte are sticky. Which commands are accepted depends on the controller state: idle, a setup write pending, engine running, or engine paused. A paused erase may have one program nested inside it.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in array-read mode and `ready` is 1. Every array byte reads FFh, and the status byte reads 80h. Status bit 7 means ready, bit 6 erase paused, bit 5 erase error, bit 4 program error, bit 3 supply error (always 0 here), bit 2 program paused and bit 1 locked-block error. Bit 0 is 0.
- R2: Each of the one-write commands FFh (array), 70h (status) and 90h (identification) selects what later reads return. In identification mode, address 0 returns 20h and address 1 returns 3Ch.
- R3: A program is a write of 40h or 10h followed by a data write to the target address. From the cycle after the second write, `ready` stays 0 for PROG_CYC cycles, and reads return the status byte.
- R4: While the engine runs, only 70h and B0h are accepted. Every other write is ignored and does not change the read mode.
- R5: A program can only clear bits: the stored byte becomes the old byte ANDed with the data.
- R6: A program or erase aimed at a locked block leaves the array unchanged and keeps `ready` at 1. A program sets status bits 4 and 1; an erase sets bits 5 and 1.
- R7: Error bits 5, 4 and 1 stay set through later successful operations. They are cleared only by the 50h command, which leaves the read mode as it was.
- R8: An erase setup write (20h) followed by any byte other than D0h starts nothing and sets status bits 5 and 4.
- R9: An erase is 20h followed by D0h, where the address of the D0h write selects the block. When the erase completes, every byte of that block reads FFh.
- R10: B0h while the engine runs pauses it. From the next cycle `ready` is 1 and status bit 2 (program) or bit 6 (erase) is set. D0h resumes the operation, which then finishes normally.
- R11: While the engine is paused, only FFh, 70h, 90h and D0h are accepted, plus 40h/10h when the paused operation is an erase. All other writes are ignored.
- R12: A program nested in a paused erase runs to completion while bit 6 stays set, and the erase then resumes on D0h. The engine never applies a program and an erase in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8 | Bus write data (command or operand) |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Bus read address |
| blk_lock | input | 2**BLK_W | Per-block lock flags, 1 = protected |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| ready | output | 1 | 1 unless the engine is running and not paused |

## Verification
The scoreboard is driven with single-write mode changes and read at identification addresses, which shows that the read multiplexer follows the mode register. Two programs to the same byte with overlapping bit patterns separate an AND merge from an overwrite. Foreign commands are written while the engine is busy and while it is paused, and then read at an address whose result would differ if the command had been taken. This separates the three acceptance filters. Locked-block, bad-confirm and nested program-in-erase-suspend sequences then exercise the sticky error bits and the two pause flags.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_READ_STAT  = 8'h70;
    localparam logic [7:0] CMD_READ_ID    = 8'h90;
    localparam logic [7:0] CMD_PROG_A     = 8'h40;
    localparam logic [7:0] CMD_PROG_B     = 8'h10;
    localparam logic [7:0] CMD_ERASE      = 8'h20;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
    localparam logic [7:0] CMD_CLEAR      = 8'h50;
    localparam logic [7:0] CMD_PAUSE      = 8'hB0;

    localparam logic [7:0] ID_CODE0 = 8'h20;
    localparam logic [7:0] ID_CODE1 = 8'h3C;

    typedef enum logic [1:0] {MODE_ARRAY, MODE_STATUS, MODE_ID} rd_mode_e;
    typedef enum logic [1:0] {PH_IDLE, PH_PROG, PH_ERASE} phase_e;

    typedef struct packed {
        logic prog_act;
        logic prog_susp;
        logic erase_act;
        logic erase_susp;
    } eng_state_t;

    typedef struct packed {
        logic erase_err;
        logic prog_err;
        logic lock_err;
    } err_t;

    function automatic logic [7:0] status_byte(input logic running,
                                               input eng_state_t e,
                                               input err_t r);
        return {~running, e.erase_susp, r.erase_err, r.prog_err,
                1'b0, e.prog_susp, r.lock_err, 1'b0};
    endfunction

    function automatic logic is_prog_cmd(input logic [7:0] d);
        return (d == CMD_PROG_A) || (d == CMD_PROG_B);
    endfunction

endpackage

// File: rtl/fcc_array.sv
module fcc_array
    import fcc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic              ee,
    input  logic [BLK_W-1:0]  eblk,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int OFS_W = ADDR_W - BLK_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (ee) begin
            for (int i = 0; i < DEPTH; i++)
                if (BLK_W'(i >> OFS_W) == eblk) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= mem[waddr] & wdata;
        end
    end

    assign rdata = mem[raddr];

    logic              chk_q;
    logic [ADDR_W-1:0] chk_addr_q;
    logic [7:0]        chk_val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_q      <= 1'b0;
            chk_addr_q <= '0;
            chk_val_q  <= 8'h00;
        end else begin
            chk_q      <= we && !ee;
            chk_addr_q <= waddr;
            chk_val_q  <= mem[waddr] & wdata;
        end
    end

    // R5: a program never sets a bit
    assert_and_merge_R5: assert property (@(posedge clk) disable iff (rst)
        chk_q |-> (mem[chk_addr_q] == chk_val_q));

endmodule

// File: rtl/fcc_engine.sv
module fcc_engine
    import fcc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BLK_W     = 2,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic              pause,
    input  logic              resume,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic [BLK_W-1:0]  op_blk,
    output eng_state_t        st,
    output logic              running,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_data,
    output logic              arr_ee,
    output logic [BLK_W-1:0]  arr_blk
);
    localparam int PCW = $clog2(PROG_CYC + 1);
    localparam int ECW = $clog2(ERASE_CYC + 1);

    logic [PCW-1:0] pcnt;
    logic [ECW-1:0] ecnt;
    logic           prog_run, erase_run;

    assign prog_run  = st.prog_act && !st.prog_susp;
    assign erase_run = st.erase_act && !st.erase_susp && !st.prog_act;
    assign running   = prog_run || erase_run;
    assign arr_we    = prog_run && (pcnt == PCW'(1));
    assign arr_ee    = erase_run && (ecnt == ECW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            pcnt     <= '0;
            ecnt     <= '0;
            arr_addr <= '0;
            arr_data <= 8'h00;
            arr_blk  <= '0;
        end else begin
            if (start_prog) begin
                st.prog_act <= 1'b1;
                pcnt        <= PCW'(PROG_CYC);
                arr_addr    <= op_addr;
                arr_data    <= op_data;
            end else if (arr_we) begin
                st.prog_act <= 1'b0;
            end else if (prog_run) begin
                pcnt <= pcnt - PCW'(1);
            end

            if (start_erase) begin
                st.erase_act <= 1'b1;
                ecnt         <= ECW'(ERASE_CYC);
                arr_blk      <= op_blk;
            end else if (arr_ee) begin
                st.erase_act <= 1'b0;
            end else if (erase_run) begin
                ecnt <= ecnt - ECW'(1);
            end

            if (pause) begin
                if (st.prog_act) st.prog_susp <= 1'b1;
                else if (st.erase_act) st.erase_susp <= 1'b1;
            end else if (resume) begin
                if (st.prog_susp) st.prog_susp <= 1'b0;
                else st.erase_susp <= 1'b0;
            end
        end
    end

    // R4: nothing new starts on top of a running operation
    assert_no_start_busy_R4: assert property (@(posedge clk) disable iff (rst)
        running |-> !(start_prog || start_erase));

    // R12: one array change per cycle
    assert_single_op_R12: assert property (@(posedge clk) disable iff (rst)
        !(arr_we && arr_ee));

    // R10: a pause takes effect at once
    assert_pause_stops_R10: assert property (@(posedge clk) disable iff (rst)
        ($rose(st.prog_susp) || $rose(st.erase_susp)) |-> !running);

    // R12: a paused erase never changes the array
    assert_erase_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        st.erase_susp |-> !arr_ee);

endmodule

// File: rtl/fcc_decoder.sv
module fcc_decoder
    import fcc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [(1<<BLK_W)-1:0]   blk_lock,
    input  eng_state_t              eng,
    input  logic                    running,
    output logic                    start_prog,
    output logic                    start_erase,
    output logic                    pause,
    output logic                    resume,
    output logic [BLK_W-1:0]        tgt_blk,
    output rd_mode_e                mode,
    output err_t                    err
);
    phase_e   phase, phase_n;
    rd_mode_e mode_n;
    err_t     err_n;
    logic     paused, locked;

    assign tgt_blk = wr_addr[ADDR_W-1 -: BLK_W];
    assign locked  = blk_lock[tgt_blk];
    assign paused  = !running && (eng.prog_susp || eng.erase_susp);

    always_comb begin
        phase_n     = phase;
        mode_n      = mode;
        err_n       = err;
        start_prog  = 1'b0;
        start_erase = 1'b0;
        pause       = 1'b0;
        resume      = 1'b0;
        if (wr_en) begin
            if (phase == PH_PROG) begin
                phase_n = PH_IDLE;
                mode_n  = MODE_STATUS;
                if (locked) begin
                    err_n.prog_err = 1'b1;
                    err_n.lock_err = 1'b1;
                end else begin
                    start_prog = 1'b1;
                end
            end else if (phase == PH_ERASE) begin
                phase_n = PH_IDLE;
                mode_n  = MODE_STATUS;
                if (wr_data != CMD_CONFIRM) begin
                    err_n.erase_err = 1'b1;
                    err_n.prog_err  = 1'b1;
                end else if (locked) begin
                    err_n.erase_err = 1'b1;
                    err_n.lock_err  = 1'b1;
                end else begin
                    start_erase = 1'b1;
                end
            end else if (running) begin
                if (wr_data == CMD_READ_STAT) mode_n = MODE_STATUS;
                else if (wr_data == CMD_PAUSE && !eng.erase_susp) begin
                    pause  = 1'b1;
                    mode_n = MODE_STATUS;
                end
            end else if (paused) begin
                case (wr_data)
                    CMD_READ_ARRAY: mode_n = MODE_ARRAY;
                    CMD_READ_STAT:  mode_n = MODE_STATUS;
                    CMD_READ_ID:    mode_n = MODE_ID;
                    CMD_CONFIRM: begin
                        resume = 1'b1;
                        mode_n = MODE_STATUS;
                    end
                    default:
                        if (is_prog_cmd(wr_data) && eng.erase_susp) begin
                            phase_n = PH_PROG;
                            mode_n  = MODE_STATUS;
                        end
                endcase
            end else begin
                case (wr_data)
                    CMD_READ_ARRAY: mode_n = MODE_ARRAY;
                    CMD_READ_STAT:  mode_n = MODE_STATUS;
                    CMD_READ_ID:    mode_n = MODE_ID;
                    CMD_CLEAR:      err_n  = '0;
                    CMD_ERASE: begin
                        phase_n = PH_ERASE;
                        mode_n  = MODE_STATUS;
                    end
                    default:
                        if (is_prog_cmd(wr_data)) begin
                            phase_n = PH_PROG;
                            mode_n  = MODE_STATUS;
                        end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            mode  <= MODE_ARRAY;
            err   <= '0;
        end else begin
            phase <= phase_n;
            mode  <= mode_n;
            err   <= err_n;
        end
    end

    // R7: error flags drop only after a clear command
    assert_sticky_prog_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(err.prog_err) |-> $past(wr_en && wr_data == CMD_CLEAR));
    assert_sticky_erase_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(err.erase_err) |-> $past(wr_en && wr_data == CMD_CLEAR));

    // R11: a paused program cannot get a second program nested
    assert_no_nest_in_prog_R11: assert property (@(posedge clk) disable iff (rst)
        (eng.prog_susp && !running) |-> !start_prog);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BLK_W     = 2,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [(1<<BLK_W)-1:0] blk_lock,
    output logic [7:0]            rd_data,
    output logic                  ready
);
    eng_state_t        eng;
    err_t              err;
    rd_mode_e          mode;
    logic              running, start_prog, start_erase, pause, resume;
    logic [BLK_W-1:0]  tgt_blk, arr_blk;
    logic              arr_we, arr_ee;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_data, arr_q;

    fcc_decoder #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dec (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .blk_lock,
        .eng, .running, .start_prog, .start_erase, .pause, .resume,
        .tgt_blk, .mode, .err
    );

    fcc_engine #(.ADDR_W(ADDR_W), .BLK_W(BLK_W),
                 .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_eng (
        .clk, .rst, .start_prog, .start_erase, .pause, .resume,
        .op_addr(wr_addr), .op_data(wr_data), .op_blk(tgt_blk),
        .st(eng), .running, .arr_we, .arr_addr, .arr_data, .arr_ee, .arr_blk
    );

    fcc_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_arr (
        .clk, .rst, .we(arr_we), .waddr(arr_addr), .wdata(arr_data),
        .ee(arr_ee), .eblk(arr_blk), .raddr(rd_addr), .rdata(arr_q)
    );

    assign ready = !running;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= 8'h00;
        end else if (rd_en) begin
            case (mode)
                MODE_ARRAY:  rd_data <= arr_q;
                MODE_STATUS: rd_data <= status_byte(running, eng, err);
                default:     rd_data <= (rd_addr == '0) ? ID_CODE0 :
                                        (rd_addr == ADDR_W'(1)) ? ID_CODE1 : 8'h00;
            endcase
        end
    end

    // R3: a second program write always leaves the part busy
    assert_busy_after_prog_R3: assert property (@(posedge clk) disable iff (rst)
        start_prog |=> !ready);

    // R6: a refused operation keeps the part ready
    assert_lock_keeps_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (ready && wr_en && !start_prog && !start_erase && !resume) |=> ready);

endmodule

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [3:0] blk_lock = '0;
    logic [7:0] rd_data;
    logic       ready;

    int vectors = 0, miscompares = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       fire = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl i_flash_cmd_ctrl (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr,
        .blk_lock, .rd_data, .ready
    );

    always @(posedge clk) fire <= rd_en;

    // monitor: compares each read result against the scoreboard queue
    always @(negedge clk) begin
        if (fire && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if (rd_data !== e) begin
                miscompares++;
                $display("FAIL %s: rd_data=%02h expected=%02h", t, rd_data, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_ready(input logic e, input string t);
        vectors++;
        if (ready !== e) begin
            miscompares++;
            $display("FAIL %s: ready=%0b expected=%0b", t, ready, e);
        end
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 200 && !ready; i++) @(negedge clk);
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_ready(1'b1, "R1 ready after reset");
        rd(8'd5, 8'hFF, "R1 array erased");
        wr(8'd0, 8'h70); rd(8'd0, 8'h80, "R1 status after reset");
        // R2 identification
        wr(8'd0, 8'h90);
        rd(8'd0, 8'h20, "R2 id code 0");
        rd(8'd1, 8'h3C, "R2 id code 1");
        // R3 program
        wr(8'd0, 8'h40); wr(8'd10, 8'hA5);
        chk_ready(1'b0, "R3 busy after program");
        rd(8'd0, 8'h00, "R3 status while busy");
        wait_ready();
        rd(8'd0, 8'h80, "R3 status when done");
        wr(8'd0, 8'hFF); rd(8'd10, 8'hA5, "R3 programmed byte");
        // R5 AND merge
        wr(8'd0, 8'h10); wr(8'd10, 8'h0F); wait_ready();
        wr(8'd0, 8'hFF); rd(8'd10, 8'h05, "R5 and merge");
        // R4 ignored while busy
        wr(8'd0, 8'h40); wr(8'd20, 8'h3C);
        wr(8'd0, 8'h90);
        rd(8'd0, 8'h00, "R4 id ignored while busy");
        wait_ready();
        rd(8'd0, 8'h80, "R4 status after busy");
        // R6 / R7 locked program, sticky bits
        blk_lock = 4'b0010;
        wr(8'd0, 8'h40); wr(8'd70, 8'h00);
        chk_ready(1'b1, "R6 locked program stays ready");
        rd(8'd0, 8'h92, "R6 locked program status");
        wr(8'd0, 8'h40); wr(8'd11, 8'h00); wait_ready();
        rd(8'd0, 8'h92, "R7 error bits sticky");
        wr(8'd0, 8'h50);
        rd(8'd0, 8'h80, "R7 clear keeps status mode");
        wr(8'd0, 8'hFF);
        rd(8'd70, 8'hFF, "R6 locked byte unchanged");
        rd(8'd11, 8'h00, "R7 program after error");
        // R8 bad confirm
        wr(8'd0, 8'h20); wr(8'd0, 8'h55);
        rd(8'd0, 8'hB0, "R8 bad confirm");
        wr(8'd0, 8'h50);
        // R6 locked erase
        wr(8'd0, 8'h20); wr(8'd64, 8'hD0);
        rd(8'd0, 8'hA2, "R6 locked erase status");
        wr(8'd0, 8'h50);
        blk_lock = 4'b0000;
        // R9 erase block 0
        wr(8'd0, 8'h20); wr(8'd0, 8'hD0);
        chk_ready(1'b0, "R9 busy during erase");
        wait_ready();
        wr(8'd0, 8'hFF);
        rd(8'd10, 8'hFF, "R9 erased byte");
        rd(8'd11, 8'hFF, "R9 erased byte 2");
        // R10 / R11 program suspend
        wr(8'd0, 8'h40); wr(8'd2, 8'h12);
        wr(8'd0, 8'hB0);
        chk_ready(1'b1, "R10 ready when paused");
        rd(8'd0, 8'h84, "R10 program paused status");
        wr(8'd0, 8'hFF);
        rd(8'd2, 8'hFF, "R10 paused program not applied");
        wr(8'd0, 8'h20);
        rd(8'd2, 8'hFF, "R11 erase setup ignored in pause");
        wr(8'd0, 8'h40); wr(8'd3, 8'h99);
        rd(8'd3, 8'hFF, "R11 program ignored in program pause");
        wr(8'd0, 8'hD0);
        chk_ready(1'b0, "R10 busy after resume");
        wait_ready();
        rd(8'd0, 8'h80, "R10 status after resume");
        wr(8'd0, 8'hFF); rd(8'd2, 8'h12, "R10 resumed program applied");
        // R12 nested program in erase suspend
        wr(8'd0, 8'h40); wr(8'd130, 8'h00); wait_ready();
        wr(8'd0, 8'h20); wr(8'd128, 8'hD0);
        wr(8'd0, 8'hB0);
        rd(8'd0, 8'hC0, "R10 erase paused status");
        wr(8'd0, 8'h40); wr(8'd200, 8'h77);
        rd(8'd0, 8'h40, "R12 nested program busy");
        wait_ready();
        rd(8'd0, 8'hC0, "R12 erase still paused");
        wr(8'd0, 8'hFF);
        rd(8'd200, 8'h77, "R12 nested program applied");
        rd(8'd130, 8'h00, "R12 paused erase not applied");
        wr(8'd0, 8'hD0); wait_ready();
        rd(8'd0, 8'h80, "R12 status after erase");
        wr(8'd0, 8'hFF);
        rd(8'd130, 8'hFF, "R9 resumed erase applied");
        rd(8'd200, 8'h77, "R9 other block untouched");
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule